// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the SCL waveform for an I2C master, together with the SDA edges that frame a transfer. Two pairs of count inputs are available, one for standard speed and one for fast speed. A three-bit control field enables the master and picks the pair. A start request makes the block pull SDA low while SCL is high, hold that state for a time derived from the high count, and then run SCL low and high phases until a stop request ends the transfer.

The low phase is counted from the cycle in which the block pulls SCL low, so software must include the line fall time in the low count. The high phase is counted only while the sampled bus line reads high, so a slave that holds SCL low lengthens the low time on the bus instead of shortening the high time. The counts are latched when a transfer starts. Counts below a safe minimum are raised to that minimum.

Top module: `scl_timer`

## Requirements
- R1: After reset, SCL and SDA are both released (`scl_drv` = 1, `sda_drv` = 1) and `busy` is 0.
- R2: A `start_req` pulse starts a transfer only when the block is idle, `ctrl[0]` (master enable) is 1, and `ctrl[1]` or `ctrl[2]` is 1. In every other case the pulse is ignored, and an ongoing transfer is not disturbed.
- R3: `ctrl[2]` = 1 selects the fast pair (`fst_hi`, `fst_lo`), even when `ctrl[1]` is also 1. Otherwise `ctrl[1]` = 1 selects the standard pair. The pair is latched at start, and later changes to `ctrl` or to the counts do not affect the running transfer.
- R4: After start, SDA is low with SCL high for high count + 3 cycles. Then SCL is pulled low.
- R5: Every low phase lasts low count + 1 cycles, counted from the cycle in which SCL is pulled low.
- R6: Every high phase lasts high count + 8 cycles, counted only while `scl_in` is high. A slave holding SCL low for S cycles makes the bus low time low count + 1 + S cycles.
- R7: A high count below 6 is used as 6, and a low count below 8 is used as 8. A value at or above the minimum is used as given.
- R8: A `stop_req` taken during a transfer ends it after the next complete low phase. SCL is then released, and SDA is released after high count + 8 counted high cycles. `busy` falls in the same cycle that SDA is released.
- R9: While a transfer runs, SDA changes only while SCL is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 3 | Bit 0 master enable; bit 1 standard speed; bit 2 fast speed |
| std_hi | input | CNT_W | Standard-speed high count |
| std_lo | input | CNT_W | Standard-speed low count |
| fst_hi | input | CNT_W | Fast-speed high count |
| fst_lo | input | CNT_W | Fast-speed low count |
| start_req | input | 1 | Single-cycle request to begin a transfer |
| stop_req | input | 1 | Single-cycle request to end the transfer |
| scl_in | input | 1 | Sampled SCL bus line |
| scl_drv | output | 1 | 0 pulls SCL low, 1 releases it |
| sda_drv | output | 1 | 0 pulls SDA low, 1 releases it |
| busy | output | 1 | A transfer is in progress |

## Verification
The bench builds the block with CNT_W = 8 and keeps the default minimums of 6 and 8. This makes the full-scale count of 255 practical to run. At that count the high phase, 263 cycles, needs the carry into the counter's extra bit. The narrow counts also keep the tests short at the clamp edges: 5 and 6 for the high count, 7 and 8 for the low count. A bus model ANDs the SCL drive with a stretch window. This shows whether the high counter waits for the line.

// File: rtl/scl_timer.sv
module scl_timer #(
  parameter int CNT_W  = 16,
  parameter int MIN_HI = 6,
  parameter int MIN_LO = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       ctrl,
  input  logic [CNT_W-1:0] std_hi,
  input  logic [CNT_W-1:0] std_lo,
  input  logic [CNT_W-1:0] fst_hi,
  input  logic [CNT_W-1:0] fst_lo,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             scl_in,
  output logic             scl_drv,
  output logic             sda_drv,
  output logic             busy
);
  localparam int PW = CNT_W + 1;

  typedef enum logic [2:0] {IDLE, HOLD, LOW, HIGH, FINAL} st_t;
  st_t st;

  logic [CNT_W-1:0] hi_q, lo_q;
  logic [PW-1:0]    cnt;
  logic             stop_pend;

  wire [CNT_W-1:0] sel_hi  = ctrl[2] ? fst_hi : std_hi;
  wire [CNT_W-1:0] sel_lo  = ctrl[2] ? fst_lo : std_lo;
  wire [CNT_W-1:0] clip_hi = (sel_hi < CNT_W'(MIN_HI)) ? CNT_W'(MIN_HI) : sel_hi;
  wire [CNT_W-1:0] clip_lo = (sel_lo < CNT_W'(MIN_LO)) ? CNT_W'(MIN_LO) : sel_lo;
  wire             go      = start_req & ctrl[0] & (ctrl[1] | ctrl[2]);
  wire             last    = (cnt == '0);

  assign scl_drv = (st != LOW);
  assign sda_drv = (st == IDLE);
  assign busy    = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      hi_q      <= CNT_W'(MIN_HI);
      lo_q      <= CNT_W'(MIN_LO);
      stop_pend <= 1'b0;
    end else begin
      if (st != IDLE && stop_req) stop_pend <= 1'b1;
      case (st)
        IDLE: if (go) begin
          hi_q      <= clip_hi;
          lo_q      <= clip_lo;
          cnt       <= PW'(clip_hi) + PW'(2);
          stop_pend <= 1'b0;
          st        <= HOLD;
        end
        HOLD: if (last) begin
          cnt <= PW'(lo_q);
          st  <= LOW;
        end else cnt <= cnt - 1'b1;
        LOW: if (last) begin
          cnt <= PW'(hi_q) + PW'(7);
          st  <= (stop_pend || stop_req) ? FINAL : HIGH;
        end else cnt <= cnt - 1'b1;
        HIGH, FINAL: if (scl_in) begin
          if (last) begin
            cnt <= PW'(lo_q);
            st  <= (st == FINAL) ? IDLE : LOW;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req) && $past(ctrl[0]) && ($past(ctrl[1]) || $past(ctrl[2])));

  // R6
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == HIGH || st == FINAL) && !scl_in) |=> $stable(cnt) && scl_drv);

  // R7
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (hi_q >= CNT_W'(MIN_HI)) && (lo_q >= CNT_W'(MIN_LO)));

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sda_drv && scl_drv && $past(scl_in));

  // R9
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drv) |-> scl_drv && $past(scl_drv));
endmodule

// File: tb/test_scl_timer.sv
`timescale 1ns/1ps
module test_scl_timer;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic [2:0] ctrl = 0;
  logic [W-1:0] std_hi = 0, std_lo = 0, fst_hi = 0, fst_lo = 0;
  logic start_req = 0, stop_req = 0;
  logic scl_drv, sda_drv, busy;
  int stretch = 0;
  int hi_age = 0;
  wire scl_bus = scl_drv & ~(hi_age < stretch);

  always #2 clk = ~clk;

  scl_timer #(.CNT_W(W)) i_scl_timer (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .std_hi(std_hi), .std_lo(std_lo),
    .fst_hi(fst_hi), .fst_lo(fst_lo), .start_req(start_req), .stop_req(stop_req),
    .scl_in(scl_bus), .scl_drv(scl_drv), .sda_drv(sda_drv), .busy(busy));

  always @(posedge clk) hi_age <= scl_drv ? ((hi_age >= 255) ? 255 : hi_age + 1) : 0;

  int checks = 0, fails = 0;
  int exp_kind[$];
  int exp_len[$];
  string exp_tag[$];
  string kname[4] = '{"hold", "low", "high", "stop"};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measures bus runs and pops the expected items from the scoreboard.
  int cyc = 0, t_sda = 0, t_fall = 0, t_rise = 0;
  bit first = 0, p_scl = 1, p_sda = 1;
  task automatic got(input int k, input int len);
    if (exp_kind.size() == 0) chk(0, "R2 unexpected edge", k, -1);
    else begin
      int ek = exp_kind.pop_front();
      int el = exp_len.pop_front();
      string tg = exp_tag.pop_front();
      chk(ek == k && el == len, {tg, " ", kname[ek]}, len, el);
    end
  endtask
  always @(negedge clk) begin
    cyc++;
    if (p_sda && !sda_drv) begin t_sda = cyc; first = 1; end
    if (p_scl && !scl_bus) begin
      if (first) begin got(0, cyc - t_sda); first = 0; end
      else got(2, cyc - t_rise);
      t_fall = cyc;
    end
    if (!p_scl && scl_bus) begin got(1, cyc - t_fall); t_rise = cyc; end
    if (!p_sda && sda_drv) got(3, cyc - t_rise);
    p_scl = scl_bus; p_sda = sda_drv;
  end

  function automatic int clampv(input int v, input int m);
    return (v < m) ? m : v;
  endfunction

  task automatic pulse_start();
    @(negedge clk) start_req = 1;
    @(negedge clk) start_req = 0;
  endtask

  // Driver: pushes expected items, then runs the transfer.
  task automatic xfer(input logic [2:0] c, input int shi, slo, fhi, flo,
                      input int n, input int s, input bit disturb, input string tg);
    int h = c[2] ? fhi : shi;
    int l = c[2] ? flo : slo;
    h = clampv(h, 6); l = clampv(l, 8);
    ctrl = c; std_hi = W'(shi); std_lo = W'(slo); fst_hi = W'(fhi); fst_lo = W'(flo);
    stretch = s;
    exp_kind.push_back(0); exp_len.push_back(h + 3); exp_tag.push_back({"R4 ", tg});
    for (int i = 0; i < n; i++) begin
      exp_kind.push_back(1); exp_len.push_back(l + 1 + s); exp_tag.push_back({(s > 0) ? "R6 " : "R5 ", tg});
      exp_kind.push_back(2); exp_len.push_back(h + 8); exp_tag.push_back({"R6 ", tg});
    end
    exp_kind.push_back(1); exp_len.push_back(l + 1 + s); exp_tag.push_back({"R5 ", tg});
    exp_kind.push_back(3); exp_len.push_back(h + 8); exp_tag.push_back({"R8 ", tg});
    pulse_start();
    for (int i = 0; i < n; i++) begin
      @(posedge scl_bus);
      if (disturb && i == 0) begin
        ctrl = 3'b011 ^ c; std_hi = 8'd40; fst_hi = 8'd50; std_lo = 8'd30; fst_lo = 8'd33;
        pulse_start();
      end
    end
    @(negedge clk) stop_req = 1;
    @(negedge clk) stop_req = 0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_kind.size() == 0, {"R8 all items seen ", tg}, exp_kind.size(), 0);
    chk(sda_drv && scl_drv && !busy, {"R8 idle after stop ", tg}, {sda_drv, scl_drv, busy}, 3'b110);
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(scl_drv == 1, "R1 scl", scl_drv, 1);
    chk(sda_drv == 1, "R1 sda", sda_drv, 1);
    chk(busy == 0, "R1 busy", busy, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    ctrl = 3'b110; std_hi = 10; std_lo = 12;
    pulse_start();
    repeat (20) @(negedge clk);
    chk(!busy && sda_drv, "R2 master disabled", busy, 0);
    ctrl = 3'b001;
    pulse_start();
    repeat (20) @(negedge clk);
    chk(!busy && sda_drv, "R2 no speed bit", busy, 0);
    xfer(3'b011, 10, 12, 30, 31, 2, 0, 0, "std");
    xfer(3'b101, 10, 12, 20, 25, 3, 0, 1, "fast+R3 disturb");
    xfer(3'b111, 11, 13, 15, 17, 1, 0, 0, "R3 both bits");
    xfer(3'b011, 10, 12, 20, 25, 2, 5, 0, "stretch");
    xfer(3'b101, 9, 9, 2, 0, 2, 0, 0, "R7 clamp low");
    xfer(3'b011, 5, 7, 1, 1, 1, 0, 0, "R7 below by one");
    xfer(3'b011, 6, 8, 1, 1, 1, 0, 0, "R7 at minimum");
    xfer(3'b101, 6, 8, 255, 255, 1, 0, 0, "full scale");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule